// File: doc/BRIEF.md
# USB Device Suspend and Resume Controller

This block watches the upstream side of a USB device controller and decides when the device is suspended and when it wakes. A run of consecutive idle cycles on the line, detected suspend signalling, or a disabled upstream hub port moves it from the active state into the suspended state. On entry it raises a suspend status flag, which software can mask onto an interrupt, and one cycle later it raises a low-power hint for the rest of the chip.

While suspended, any non-idle line state brings the block straight back to active. Software can also ask for a device-initiated wake. The request is honoured only while the block is suspended and only after the host has granted remote wakeup, a grant that reset removes. An honoured request drives resume signalling to the transmitter for a programmed number of milliseconds. After that the block returns to active. A request made without the grant is dropped and recorded in a sticky error bit. Enumeration state such as the device address lives outside this block and is never touched by it.

Top module: `usb_susp_ctl`

## Requirements
- R1: In the active state, when `line_active` has been sampled low on L consecutive clock edges, the block is suspended after the L-th such edge. L is `idle_cycles`, or 3*MS_CYCLES when `idle_cycles` is 0. A sampled high `line_active` restarts the count.
- R2: In the active state, `susp_sig` or `port_dis` sampled high puts the block in the suspended state at that same edge.
- R3: `susp_flag` is set at the edge where the block moves from active to suspended. `susp_irq` always equals `susp_flag` AND `susp_ie`.
- R4: `susp_w1c` high clears `susp_flag`, unless the flag is being set at the same edge, in which case the set wins. The flag also clears at the edge where the block returns to active from suspend or from resume drive.
- R5: In the suspended state, `line_active` sampled high returns the block to active at that edge, even if `force_res` is high at the same edge. In that case the request neither drives resume nor sets the error bit.
- R6: `force_res` sampled in the active state has no effect. `drive_resume`, `wake_err` and `low_power` are unchanged.
- R7: `rwu_en` is 0 after reset. `rwu_set` sets it and `rwu_clr` clears it, and `rwu_clr` wins when both are high at the same edge.
- R8: In the suspended state with `rwu_en` high, `force_res` makes `drive_resume` high for exactly max(`res_ms`,1)*MS_CYCLES cycles, starting at that edge. The block then returns to active with `susp_flag` cleared.
- R9: In the suspended state with `rwu_en` low, `force_res` drives no resume and sets the sticky bit `wake_err`. `err_w1c` clears `wake_err`, and a set at the same edge wins.
- R10: `low_power` rises one edge after suspend entry. It falls at the edge where the block leaves the suspended state.
- R11: While resume is being driven, `line_active`, `susp_sig` and `port_dis` do not shorten or end the drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_active | input | 1 | 1 when the upstream line shows non-idle signalling |
| susp_sig | input | 1 | Suspend signalling detected upstream |
| port_dis | input | 1 | Upstream hub port is disabled |
| idle_cycles | input | CNT_W | Idle period in cycles, 0 selects 3 ms |
| res_ms | input | 4 | Resume drive length in ms, 0 treated as 1 |
| force_res | input | 1 | Software write of 1 to force resume |
| rwu_set | input | 1 | Host granted remote wakeup |
| rwu_clr | input | 1 | Host withdrew remote wakeup |
| susp_ie | input | 1 | Suspend interrupt enable |
| susp_w1c | input | 1 | Write 1 to clear the suspend flag |
| err_w1c | input | 1 | Write 1 to clear the wake error bit |
| susp_flag | output | 1 | Suspend status flag |
| susp_irq | output | 1 | Masked suspend interrupt |
| drive_resume | output | 1 | Request to the transmitter to drive resume signalling |
| low_power | output | 1 | Low-power hint |
| rwu_en | output | 1 | Remote wakeup currently granted |
| wake_err | output | 1 | Sticky: a wake request was dropped for lack of a grant |

## Verification
Host-side wake and a software wake request can land on the same edge while the block is suspended. The bench raises `line_active` and `force_res` together and expects the return to active to win, with no resume drive and no error bit. A second collision is suspend entry meeting a `susp_w1c` write. The bench lines up `susp_sig` with the clear pulse and expects the flag to stay set. A behavioural model predicts every output on every clock. Directed counts of idle cycles and drive length pin down the timing boundaries.

// File: rtl/susp_pkg.sv
package susp_pkg;

  typedef enum logic [1:0] {
    ST_ACT  = 2'd0,
    ST_SUSP = 2'd1,
    ST_RES  = 2'd2
  } susp_st_e;

endpackage

// File: rtl/susp_idle_timer.sv
// Counts consecutive idle cycles while the link is active and flags the
// cycle in which the programmed idle period is reached.
module susp_idle_timer #(
  parameter int CNT_W = 20,
  parameter int DFLT  = 750000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             line_active,
  input  logic [CNT_W-1:0] idle_cycles,
  output logic             hit
);

  localparam logic [CNT_W-1:0] DFLT_V = CNT_W'(DFLT);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic [CNT_W:0]   cnt_inc;
  logic             cnt_en;

  always_comb begin
    lim     = (idle_cycles == '0) ? DFLT_V : idle_cycles;
    cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    hit     = run && !line_active && (cnt_inc >= {1'b0, lim});
    cnt_en  = run || (cnt_q != '0);
    if (!run || line_active || hit) cnt_d = '0;
    else                            cnt_d = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R1: each idle cycle below the limit advances the count by one
  a_r1_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !line_active && !hit) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R1: activity restarts the count
  a_r1_activity_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_active |=> (cnt_q == '0));

endmodule

// File: rtl/susp_drive_timer.sv
// Times the resume drive: loaded with the duration, counts down while running.
module susp_drive_timer #(
  parameter int MS_CYCLES = 250000,
  parameter int DUR_W     = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic [3:0] res_ms,
  output logic       done
);

  localparam logic [DUR_W-1:0] MS_V = DUR_W'(MS_CYCLES);

  logic [DUR_W-1:0] cnt_q, cnt_d, dur;
  logic [3:0]       ms_eff;
  logic             cnt_en;

  always_comb begin
    ms_eff = (res_ms == 4'd0) ? 4'd1 : res_ms;
    dur    = DUR_W'(ms_eff) * MS_V;
    done   = run && (cnt_q == '0);
    cnt_en = load || (run && (cnt_q != '0));
    if (load) cnt_d = dur - 1'b1;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: a load sets up a drive of the full programmed length
  a_r8_load_len: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(dur) - 1'b1));

  // R8: the countdown is monotonic while the drive runs
  a_r8_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/susp_fsm.sv
// Suspend/resume state machine with status, error and wakeup-grant flags.
module susp_fsm
  import susp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_active,
  input  logic     susp_sig,
  input  logic     port_dis,
  input  logic     force_res,
  input  logic     rwu_set,
  input  logic     rwu_clr,
  input  logic     susp_w1c,
  input  logic     err_w1c,
  input  logic     idle_hit,
  input  logic     drive_done,
  output susp_st_e state,
  output logic     drive_load,
  output logic     susp_flag,
  output logic     low_power,
  output logic     rwu_en,
  output logic     wake_err
);

  susp_st_e st_q, st_d;
  logic     flag_q, flag_d, lp_q, lp_d, rwu_q, rwu_d, err_q, err_d;
  logic     enter_susp, back_active, err_set;

  // next state
  always_comb begin
    st_d       = st_q;
    drive_load = 1'b0;
    err_set    = 1'b0;
    unique case (st_q)
      ST_ACT: begin
        if (idle_hit || susp_sig || port_dis) st_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (line_active) begin
          st_d = ST_ACT;
        end else if (force_res && rwu_q) begin
          st_d       = ST_RES;
          drive_load = 1'b1;
        end else if (force_res) begin
          err_set = 1'b1;
        end
      end
      ST_RES: begin
        if (drive_done) st_d = ST_ACT;
      end
      default: st_d = ST_ACT;
    endcase
  end

  // next flags
  always_comb begin
    enter_susp = (st_q == ST_ACT) && (st_d == ST_SUSP);
    back_active = (st_q != ST_ACT) && (st_d == ST_ACT);

    flag_d = flag_q;
    if (susp_w1c || back_active) flag_d = 1'b0;
    if (enter_susp)              flag_d = 1'b1;

    lp_d = (st_q == ST_SUSP) && (st_d == ST_SUSP);

    rwu_d = rwu_q;
    if (rwu_set) rwu_d = 1'b1;
    if (rwu_clr) rwu_d = 1'b0;

    err_d = err_q;
    if (err_w1c) err_d = 1'b0;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_ACT;
      flag_q <= 1'b0;
      lp_q   <= 1'b0;
      rwu_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
      lp_q   <= lp_d;
      rwu_q  <= rwu_d;
      err_q  <= err_d;
    end
  end

  assign state     = st_q;
  assign susp_flag = flag_q;
  assign low_power = lp_q;
  assign rwu_en    = rwu_q;
  assign wake_err  = err_q;

  // R2: suspend signalling or a disabled port suspends at once
  a_r2_sig_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && (susp_sig || port_dis)) |=> (st_q == ST_SUSP && flag_q));

  // R5: host activity while suspended wins over a wake request
  a_r5_host_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUSP && line_active) |=> (st_q == ST_ACT && !flag_q && !lp_q));

  // R6: a wake request while active cannot start a drive
  a_r6_active_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT) |=> (st_q != ST_RES));

  // R7: a withdrawn grant is gone on the next cycle
  a_r7_rwu_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rwu_clr |=> !rwu_q);

  // R9: the error bit is sticky until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_w1c) |=> err_q);

  // R10: the low-power hint only appears while suspended
  a_r10_lp_in_susp: assert property (@(posedge clk) disable iff (!rst_n)
    lp_q |-> (st_q == ST_SUSP));

  // R11: a running drive is never cut short by line activity
  a_r11_drive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RES && !drive_done) |=> (st_q == ST_RES));

endmodule

// File: rtl/usb_susp_ctl.sv
module usb_susp_ctl
  import susp_pkg::*;
#(
  parameter int MS_CYCLES = 250000,
  parameter int CNT_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_active,
  input  logic             susp_sig,
  input  logic             port_dis,
  input  logic [CNT_W-1:0] idle_cycles,
  input  logic [3:0]       res_ms,
  input  logic             force_res,
  input  logic             rwu_set,
  input  logic             rwu_clr,
  input  logic             susp_ie,
  input  logic             susp_w1c,
  input  logic             err_w1c,
  output logic             susp_flag,
  output logic             susp_irq,
  output logic             drive_resume,
  output logic             low_power,
  output logic             rwu_en,
  output logic             wake_err
);

  localparam int IDLE_DFLT = 3 * MS_CYCLES;
  localparam int DUR_W     = $clog2(15 * MS_CYCLES + 1);

  susp_st_e state;
  logic     idle_hit, drive_done, drive_load;

  susp_idle_timer #(
    .CNT_W (CNT_W),
    .DFLT  (IDLE_DFLT)
  ) idle_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (state == ST_ACT),
    .line_active (line_active),
    .idle_cycles (idle_cycles),
    .hit         (idle_hit)
  );

  susp_drive_timer #(
    .MS_CYCLES (MS_CYCLES),
    .DUR_W     (DUR_W)
  ) drive_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (drive_load),
    .run    (state == ST_RES),
    .res_ms (res_ms),
    .done   (drive_done)
  );

  susp_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_active (line_active),
    .susp_sig    (susp_sig),
    .port_dis    (port_dis),
    .force_res   (force_res),
    .rwu_set     (rwu_set),
    .rwu_clr     (rwu_clr),
    .susp_w1c    (susp_w1c),
    .err_w1c     (err_w1c),
    .idle_hit    (idle_hit),
    .drive_done  (drive_done),
    .state       (state),
    .drive_load  (drive_load),
    .susp_flag   (susp_flag),
    .low_power   (low_power),
    .rwu_en      (rwu_en),
    .wake_err    (wake_err)
  );

  assign drive_resume = (state == ST_RES);
  assign susp_irq     = susp_flag & susp_ie;

  // R3: the interrupt follows the flag under its enable
  a_r3_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    susp_irq |-> (susp_flag && susp_ie));

  // R8: a drive ends with the flag cleared
  a_r8_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_resume) |-> !susp_flag);

endmodule

// File: tb/usb_susp_ctl_tb_top.sv
`timescale 1ns/1ps
module usb_susp_ctl_tb_top;

  localparam int MS    = 16;
  localparam int CW    = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_active, susp_sig, port_dis, force_res;
  logic          rwu_set, rwu_clr, susp_ie, susp_w1c, err_w1c;
  logic [CW-1:0] idle_cycles;
  logic [3:0]    res_ms;
  logic          susp_flag, susp_irq, drive_resume, low_power, rwu_en, wake_err;

  int n_chk = 0;
  int n_err = 0;

  // behavioural reference state: 0 active, 1 suspended, 2 driving resume
  int m_st, m_idle, m_rem, m_flag, m_lp, m_rwu, m_err;

  always #2 clk = ~clk;

  usb_susp_ctl #(.MS_CYCLES(MS), .CNT_W(CW)) dut_i (
    .clk, .rst_n, .line_active, .susp_sig, .port_dis, .idle_cycles, .res_ms,
    .force_res, .rwu_set, .rwu_clr, .susp_ie, .susp_w1c, .err_w1c,
    .susp_flag, .susp_irq, .drive_resume, .low_power, .rwu_en, .wake_err
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_idle = 0; m_rem = 0; m_flag = 0; m_lp = 0; m_rwu = 0; m_err = 0;
  endtask

  task automatic model_tick();
    int lim, nst, nflag, nerr, eset;
    lim  = (idle_cycles == 0) ? 3 * MS : int'(idle_cycles);
    nst  = m_st;
    eset = 0;
    if (m_st == 0) begin
      if (susp_sig || port_dis || (!line_active && m_idle + 1 >= lim)) nst = 1;
      m_idle = line_active ? 0 : m_idle + 1;
    end else if (m_st == 1) begin
      if (line_active) nst = 0;
      else if (force_res && m_rwu == 1) begin
        nst   = 2;
        m_rem = ((res_ms == 0) ? 1 : int'(res_ms)) * MS;
      end else if (force_res) eset = 1;
    end else begin
      m_rem--;
      if (m_rem == 0) nst = 0;
    end
    if (nst != 0) m_idle = 0;
    nflag = m_flag;
    if (susp_w1c || (m_st != 0 && nst == 0)) nflag = 0;
    if (m_st == 0 && nst == 1) nflag = 1;
    nerr = m_err;
    if (err_w1c) nerr = 0;
    if (eset) nerr = 1;
    m_lp = (m_st == 1 && nst == 1) ? 1 : 0;
    if (rwu_set) m_rwu = 1;
    if (rwu_clr) m_rwu = 0;
    m_st = nst; m_flag = nflag; m_err = nerr;
  endtask

  task automatic compare();
    chk("R3 susp_flag", int'(susp_flag), m_flag);
    chk("R3 susp_irq", int'(susp_irq), m_flag & int'(susp_ie));
    chk("R8 drive_resume", int'(drive_resume), (m_st == 2) ? 1 : 0);
    chk("R10 low_power", int'(low_power), m_lp);
    chk("R7 rwu_en", int'(rwu_en), m_rwu);
    chk("R9 wake_err", int'(wake_err), m_err);
  endtask

  task automatic step();
    @(posedge clk);
    model_tick();
    #1;
    compare();
  endtask

  task automatic pulse_susp();
    susp_sig = 1'b1; step(); susp_sig = 1'b0; step();
  endtask

  task automatic wake_host();
    line_active = 1'b1; step(); step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R1..R11 run actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    line_active = 1'b1; susp_sig = 1'b0; port_dis = 1'b0; force_res = 1'b0;
    rwu_set = 1'b0; rwu_clr = 1'b0; susp_ie = 1'b1; susp_w1c = 1'b0; err_w1c = 1'b0;
    idle_cycles = CW'(10); res_ms = 4'd2;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    compare();
    chk("R7 rwu_en low after reset", int'(rwu_en), 0);
    rst_n = 1'b1;
    step(); step();

    // R1: programmed idle period, with one restart midway
    line_active = 1'b0;
    repeat (6) step();
    line_active = 1'b1; step();
    line_active = 1'b0;
    n = 0;
    while (!susp_flag && n < 200) begin step(); n++; end
    chk("R1 idle cycles to suspend", n, 10);
    chk("R10 low_power not yet", int'(low_power), 0);
    step();
    chk("R10 low_power one cycle later", int'(low_power), 1);
    chk("R3 irq with enable", int'(susp_irq), 1);
    susp_ie = 1'b0; step();
    chk("R3 irq masked", int'(susp_irq), 0);
    susp_ie = 1'b1;

    // R4: clear while suspended, then host wake
    susp_w1c = 1'b1; step(); susp_w1c = 1'b0;
    chk("R4 flag cleared by write", int'(susp_flag), 0);
    chk("R4 still suspended", int'(low_power), 1);
    line_active = 1'b1; step();
    chk("R5 host wake leaves low power", int'(low_power), 0);
    step();

    // R1: default period when idle_cycles is 0
    idle_cycles = '0;
    line_active = 1'b0;
    n = 0;
    while (!susp_flag && n < 500) begin step(); n++; end
    chk("R1 default idle period", n, 3 * MS);
    wake_host();

    // R2: suspend signalling and disabled port
    susp_sig = 1'b1; step(); susp_sig = 1'b0;
    chk("R2 suspend signalling enters", int'(susp_flag), 1);
    wake_host();
    port_dis = 1'b1; step(); port_dis = 1'b0;
    chk("R2 port disable enters", int'(susp_flag), 1);
    wake_host();
    idle_cycles = CW'(10);

    // R4: entry and clear on the same edge, set wins
    susp_sig = 1'b1; susp_w1c = 1'b1; step(); susp_sig = 1'b0; susp_w1c = 1'b0;
    chk("R4 set beats clear", int'(susp_flag), 1);
    wake_host();

    // R6: wake request while active
    force_res = 1'b1; step(); step(); force_res = 1'b0;
    chk("R6 no drive while active", int'(drive_resume), 0);
    chk("R6 no error while active", int'(wake_err), 0);
    chk("R6 no low power while active", int'(low_power), 0);

    // R9: wake request without grant
    line_active = 1'b0;
    pulse_susp();
    force_res = 1'b1; step(); force_res = 1'b0;
    chk("R9 dropped request no drive", int'(drive_resume), 0);
    chk("R9 error set", int'(wake_err), 1);
    step(); step();
    chk("R9 error sticky", int'(wake_err), 1);
    err_w1c = 1'b1; step(); err_w1c = 1'b0;
    chk("R9 error cleared", int'(wake_err), 0);

    // R7: set and clear together leaves grant off, then grant
    rwu_set = 1'b1; rwu_clr = 1'b1; step(); rwu_clr = 1'b0;
    chk("R7 clear wins", int'(rwu_en), 0);
    step(); rwu_set = 1'b0;
    chk("R7 grant set", int'(rwu_en), 1);

    // R5: host wake and wake request on the same edge
    line_active = 1'b1; force_res = 1'b1; step(); force_res = 1'b0;
    chk("R5 host wake wins no drive", int'(drive_resume), 0);
    chk("R5 host wake wins no error", int'(wake_err), 0);
    chk("R5 flag cleared on wake", int'(susp_flag), 0);
    step();

    // R8 and R11: granted wake, 2 ms, with line activity during the drive
    line_active = 1'b0;
    pulse_susp();
    res_ms = 4'd2;
    force_res = 1'b1; step(); force_res = 1'b0;
    chk("R10 low_power drops at resume start", int'(low_power), 0);
    line_active = 1'b1; susp_sig = 1'b1;
    n = 0;
    while (drive_resume && n < 1000) begin step(); n++; end
    susp_sig = 1'b0;
    chk("R11 drive length with line activity", n, 2 * MS);
    chk("R8 flag cleared after drive", int'(susp_flag), 0);
    step();

    // R8: res_ms of 0 behaves as 1 ms
    line_active = 1'b0;
    pulse_susp();
    res_ms = 4'd0;
    force_res = 1'b1; step(); force_res = 1'b0;
    n = 0;
    while (drive_resume && n < 1000) begin step(); n++; end
    chk("R8 zero length treated as 1 ms", n, MS);
    line_active = 1'b1;
    step(); step();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule